// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for every cycle of a burst of up to four words in a synchronous burst memory. A burst begins when one of two address strobes is accepted: one meant for a processor and one meant for a cache controller. On that edge the whole external address is captured. Its two lowest bits become the seed of a 2-bit beat counter.

Each later beat comes from inside the block. The beat counter steps only on edges where the advance input is high and no new burst is accepted. The upper address bits stay fixed for the whole burst. The two low bits follow either linear order, (seed + beat) mod 4, or interleaved order, seed XOR beat. The order is chosen by a static order-select input, which is captured when the burst begins.

A registered start flag marks the first cycle of every accepted burst. All inputs are sampled on the rising clock edge. Results appear at the outputs right after that edge. The memory array, the data path and the output drivers are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: When a burst start is accepted on a rising edge, `word_addr` equals the captured `addr_in` after that edge, and `burst_start` is 1 for that one cycle.
- R2: A high `ctrl_strobe` starts a burst whatever the level of `chip_en`.
- R3: A high `proc_strobe` starts a burst only while `chip_en` is 1. With `chip_en` at 0 and no controller strobe, it is ignored: `burst_start` stays 0, and with `advance` low `word_addr` keeps its value.
- R4: When both strobes are high in the same cycle, exactly one burst start is accepted. The processor strobe has priority, and the result is the same single load of `addr_in`.
- R5: With order select 0 (linear) captured at burst start, the low two bits of `word_addr` equal (seed + beat) mod 4. The seed is `addr_in[1:0]` at start, and beat is the number of accepted advances since start, mod 4.
- R6: With order select 1 (interleaved) captured at burst start, the low two bits equal seed XOR beat. A change of `order_sel` during a burst has no effect on that burst.
- R7: On an edge with `advance` low and no accepted start, `word_addr` keeps its value.
- R8: Between burst starts, `word_addr[ADDR_W-1:2]` stays equal to the captured address.
- R9: After four accepted advances, the low bits return to the seed value.
- R10: After reset, `word_addr` is 0 and `burst_start` is 0.
- R11: `burst_start` is 0 after any edge that accepted no burst start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_strobe | input | 1 | Processor address strobe, active high, qualified by chip_en |
| ctrl_strobe | input | 1 | Controller address strobe, active high |
| chip_en | input | 1 | Primary chip enable, active high |
| advance | input | 1 | Step to the next beat |
| order_sel | input | 1 | 0 = linear, 1 = interleaved; captured at burst start |
| addr_in | input | ADDR_W | External word address |
| word_addr | output | ADDR_W | Current word address |
| burst_start | output | 1 | High in the first cycle of an accepted burst |

## Verification
A wrong seed, beat count or captured order shows up on the low two bits of `word_addr` one edge after the faulty update. A wrong order alone may stay hidden until the beat count leaves zero. A corrupted upper register shows at once as an upper-bit mismatch that lasts until the next burst start. A wrong start decision, such as a processor strobe taken without enable or a lost controller strobe, shows on `burst_start` and on the whole address one edge after the strobe.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } beat_order_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PROC = 2'd1,
    SRC_CTRL = 2'd2
  } start_src_e;
endpackage

// File: rtl/start_arbiter.sv
module start_arbiter
  import burst_seq_pkg::*;
(
  input  logic       proc_strobe,
  input  logic       ctrl_strobe,
  input  logic       chip_en,
  output logic       load_en,
  output start_src_e load_src
);
  logic proc_ok;

  always_comb begin
    proc_ok  = proc_strobe & chip_en;
    load_src = SRC_NONE;
    if (proc_ok)          load_src = SRC_PROC;  // processor wins (R4)
    else if (ctrl_strobe) load_src = SRC_CTRL;
    load_en = (load_src != SRC_NONE);
  end

  // R3 / R2: the decision follows the strobes and the enable
  always_comb begin
    if (proc_strobe && !chip_en && !ctrl_strobe)
      p_proc_gated_r3: assert (!load_en);
    if (ctrl_strobe)
      p_ctrl_starts_r2: assert (load_en);
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter
  import burst_seq_pkg::*;
#(
  parameter int unsigned CNT_W = BEAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             advance,
  input  logic [CNT_W-1:0] seed_in,
  input  logic             order_in,
  output logic [CNT_W-1:0] seed_q,
  output logic [CNT_W-1:0] beat_q,
  output beat_order_e      order_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] seed_d, beat_d;
  beat_order_e      order_d;
  logic             seed_en, beat_en;

  always_comb begin
    seed_en = load_en;
    beat_en = load_en | advance;
    seed_d  = seed_in;
    order_d = beat_order_e'(order_in);
    beat_d  = load_en ? '0 : beat_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q  <= '0;
      order_q <= ORDER_LINEAR;
    end else if (seed_en) begin
      seed_q  <= seed_d;
      order_q <= order_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && advance && beat_q == {CNT_W{1'b1}}) |=> (beat_q == '0));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !advance) |=> ($stable(beat_q) && $stable(seed_q)));
  p_order_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(order_q));
endmodule

// File: rtl/order_map.sv
module order_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned CNT_W = BEAT_W
) (
  input  logic [CNT_W-1:0] seed,
  input  logic [CNT_W-1:0] beat,
  input  beat_order_e      order,
  output logic [CNT_W-1:0] low_addr
);
  logic [CNT_W-1:0] lin, ilv;

  genvar b;
  generate
    for (b = 0; b < CNT_W; b++) begin : g_xor
      assign ilv[b] = seed[b] ^ beat[b];
    end
  endgenerate

  always_comb begin
    lin      = seed + beat;
    low_addr = (order == ORDER_INTERLEAVE) ? ilv : lin;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_strobe,
  input  logic              ctrl_strobe,
  input  logic              chip_en,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] word_addr,
  output logic              burst_start
);
  localparam int unsigned UP_W = ADDR_W - BEAT_W;

  logic              load_en;
  start_src_e        load_src;
  logic [BEAT_W-1:0] seed_q, beat_q, low_addr;
  beat_order_e       order_q;
  logic [UP_W-1:0]   upper_d, upper_q;
  logic              start_d;

  start_arbiter u_arb (
    .proc_strobe (proc_strobe),
    .ctrl_strobe (ctrl_strobe),
    .chip_en     (chip_en),
    .load_en     (load_en),
    .load_src    (load_src)
  );

  beat_counter #(.CNT_W(BEAT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .advance  (advance),
    .seed_in  (addr_in[BEAT_W-1:0]),
    .order_in (order_sel),
    .seed_q   (seed_q),
    .beat_q   (beat_q),
    .order_q  (order_q)
  );

  order_map #(.CNT_W(BEAT_W)) u_map (
    .seed     (seed_q),
    .beat     (beat_q),
    .order    (order_q),
    .low_addr (low_addr)
  );

  always_comb begin
    upper_d = addr_in[ADDR_W-1:BEAT_W];
    start_d = load_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       upper_q <= '0;
    else if (load_en) upper_q <= upper_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_start <= 1'b0;
    else        burst_start <= start_d;
  end

  assign word_addr = {upper_q, low_addr};

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_strobe || (proc_strobe && chip_en)) |=> (word_addr == $past(addr_in) && burst_start));
  p_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_strobe && !(proc_strobe && chip_en)) |=> !burst_start);
  p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(word_addr[ADDR_W-1:BEAT_W]));
  p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !advance) |=> $stable(word_addr));
  p_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe && chip_en && ctrl_strobe) |-> (load_src == SRC_PROC));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 18;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic proc_strobe = 0, ctrl_strobe = 0, chip_en = 0, advance = 0, order_sel = 0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] word_addr;
  logic burst_start;

  int checks = 0, failures = 0;
  bit done = 0;

  // model state
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_seed = 0, m_beat = 0;
  logic m_mode = 0, m_bs = 0;
  string m_tag = "R10";

  always #(CLK_P/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .proc_strobe(proc_strobe), .ctrl_strobe(ctrl_strobe),
    .chip_en(chip_en), .advance(advance), .order_sel(order_sel), .addr_in(addr_in),
    .word_addr(word_addr), .burst_start(burst_start));

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = m_mode ? (m_seed ^ m_beat) : 2'(m_seed + m_beat);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic chk_addr(string tag);
    checks++;
    if (word_addr !== exp_addr()) begin
      failures++;
      $display("FAIL %s word_addr actual=%h expected=%h", tag, word_addr, exp_addr());
    end
  endtask

  task automatic chk_bs(string tag);
    checks++;
    if (burst_start !== m_bs) begin
      failures++;
      $display("FAIL %s burst_start actual=%0b expected=%0b", tag, burst_start, m_bs);
    end
  endtask

  // drive at negedge, model the coming edge, check at the following negedge
  task automatic cyc(logic ps, logic cs, logic ce, logic adv, logic md, logic [AW-1:0] a);
    logic ld;
    proc_strobe = ps; ctrl_strobe = cs; chip_en = ce; advance = adv; order_sel = md; addr_in = a;
    ld = (ps && ce) || cs;
    if (ld) begin
      m_base = a; m_seed = a[1:0]; m_beat = 0; m_mode = md; m_bs = 1; m_tag = "R1";
    end else begin
      m_bs = 0;
      if (adv) begin m_beat = m_beat + 2'd1; m_tag = m_mode ? "R6" : "R5"; end
      else m_tag = "R7";
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_addr("R10"); chk_bs("R10");

    // controller strobe with enable low, linear, seed 3
    cyc(0, 1, 0, 0, 0, 18'h2A5F3);
    chk_addr("R2"); chk_bs("R1");
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 1, 0, $urandom);
      chk_addr("R5"); chk_bs("R11");
    end
    checks++;
    if (word_addr !== 18'h2A5F3) begin
      failures++; $display("FAIL R9 wrap actual=%h expected=%h", word_addr, 18'h2A5F3);
    end
    checks++;
    if (word_addr[AW-1:2] !== 16'hA97C) begin
      failures++; $display("FAIL R8 upper actual=%h expected=%h", word_addr[AW-1:2], 16'hA97C);
    end

    // processor strobe without enable is ignored
    held = word_addr;
    cyc(1, 0, 0, 0, 1, 18'h01234);
    chk_bs("R3");
    checks++;
    if (word_addr !== held) begin
      failures++; $display("FAIL R3 word_addr actual=%h expected=%h", word_addr, held);
    end

    // processor strobe with enable, interleaved seed 2, mode flips mid-burst
    cyc(1, 0, 1, 1, 1, 18'h3FFFE);
    chk_addr("R1"); chk_bs("R1");
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 1, 1, 0, '0);
      chk_addr("R6");
    end

    // stall
    held = word_addr;
    cyc(0, 0, 1, 0, 0, 18'h15555);
    checks++;
    if (word_addr !== held) begin
      failures++; $display("FAIL R7 hold actual=%h expected=%h", word_addr, held);
    end

    // both strobes
    cyc(1, 1, 1, 1, 0, 18'h0ABC1);
    chk_addr("R4"); chk_bs("R4");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic ps, cs;
      ps = ($urandom % 8) == 0;
      cs = ($urandom % 10) == 0;
      cyc(ps, cs, 1'($urandom), 1'($urandom), 1'($urandom), 18'($urandom));
      chk_addr(m_tag);
      chk_bs(m_bs ? "R1" : "R11");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule